// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a stereo PCM stream made of three wires: a bit clock, a frame clock that separates the two channels, and a data line. It turns the stream into parallel samples. A fast system clock oversamples all three wires. Each rising edge of the bit clock becomes a one-cycle strobe, and the data bit and frame-clock level are taken at that strobe.

A two-bit format input picks one of four framings. A second two-bit input picks the word length. Every word is sign-extended to 24 bits. Once per stereo frame, the left and right samples are presented together with a one-cycle valid pulse.

Each channel also has a silence flag. The flag rises after a long run of all-zero samples, and it drops on the first sample that is not zero.

Top module: `serial_audio_rx`

## Requirements
- R1: The format code is decoded as follows: 00 right-justified, 01 I2S-style, 10 left-justified, 11 DSP. Data is sampled on bit-clock rising edges, most-significant bit first, as twos-complement words.
- R2: Left-justified framing:
  - A high frame clock marks the left channel.
  - The word MSB is the first bit after a frame-clock transition.
  - Bits after the word in the same half are ignored.
- R3: I2S-style framing:
  - A low frame clock marks the left channel.
  - The MSB is the second bit after a frame-clock transition.
  - All other bits of the half are ignored.
- R4: Right-justified framing:
  - A high frame clock marks the left channel.
  - The word LSB is the last bit before the next frame-clock transition.
  - Earlier bits of the half are ignored.
- R5: DSP framing:
  - A frame clock that is high for one bit marks the start of a frame.
  - The left MSB is the next bit.
  - The right word follows the left LSB with no gap.
  - Bits after the right word are ignored until the next sync.
- R6: Word length is selected as 00 = 16, 01 = 18, 10 = 20 and 11 = 24 bits. The received word is sign-extended to 24 bits on both outputs.
- R7: The valid output pulses high for exactly one system clock per stereo frame. The two sample outputs are loaded in that same cycle and hold their values between pulses.
- R8: The bit clock may pause while low, for any number of system clocks, without changing the received samples.
- R9: A channel's zero flag rises when a frame is presented whose sample for that channel is zero and that comes after ZERO_FRAMES consecutive zero samples on the same channel. That makes it the (ZERO_FRAMES+1)-th zero in a row.
- R10: A zero flag falls on the first presented frame whose sample for that channel is nonzero. The two channels are tracked independently.
- R11: While reset is high, the following are held low: valid, both samples and both flags. After reset, no sample is produced until a frame boundary has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Framing format code |
| word_sel | input | 2 | Word length code |
| bclk | input | 1 | Serial bit clock, may be gated |
| lrclk | input | 1 | Frame / channel clock |
| sdata | input | 1 | Serial data |
| left_out | output | 24 | Sign-extended left sample |
| right_out | output | 24 | Sign-extended right sample |
| out_valid | output | 1 | One-cycle strobe per stereo frame |
| zero_left | output | 1 | Left channel silence flag |
| zero_right | output | 1 | Right channel silence flag |

## Verification
Every format is swept against every word length. The sample values cover:
- the positive and negative extremes,
- minus one and plus one,
- an alternating bit pattern,
- hashed values.

These patterns separate a missing sign extension from a bit-order or off-by-one framing fault.

Unused slots are filled with an alternating pattern instead of zeros, so a framing that reads one bit early or late produces visibly wrong words. Half of the runs pause the bit clock at random points, which separates edge-based sampling from any dependence on a steady bit rate.

A dedicated run feeds a left channel with zero runs of exactly the threshold length and one longer. Alongside it, the right channel stays just below the threshold. This run shows whether the flag rises on the right frame and whether it clears on the first nonzero sample.

// File: rtl/sar_pkg.sv
package sar_pkg;

   localparam int MAX_W = 24;

   typedef enum logic [1:0] {
      FMT_RJ  = 2'b00,
      FMT_I2S = 2'b01,
      FMT_LJ  = 2'b10,
      FMT_DSP = 2'b11
   } fmt_e;

   // word length for a two-bit length code
   function automatic logic [5:0] word_len(input logic [1:0] sel);
      case (sel)
         2'b00:   return 6'd16;
         2'b01:   return 6'd18;
         2'b10:   return 6'd20;
         default: return 6'd24;
      endcase
   endfunction

   // raw word sits in the low bits; replicate its top bit upward
   function automatic logic [MAX_W-1:0] sign_fill(input logic [MAX_W-1:0] raw,
                                                  input logic [1:0] sel);
      logic [5:0]              pad;
      logic signed [MAX_W-1:0] t;
      pad = 6'(MAX_W) - word_len(sel);
      t   = $signed(raw << pad);
      return $unsigned(t >>> pad);
   endfunction

endpackage

// File: rtl/sar_capture.sv
module sar_capture #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic bclk,
   input  logic lrclk,
   input  logic sdata,
   output logic bit_stb,
   output logic lr_bit,
   output logic sd_bit
);

   // bit 0 bclk, bit 1 lrclk, bit 2 sdata
   logic [STAGES-1:0][2:0] pipe;
   logic                   bclk_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pipe   <= '0;
         bclk_q <= 1'b0;
      end else begin
         pipe[0] <= {sdata, lrclk, bclk};
         for (int i = 1; i < STAGES; i++) begin
            pipe[i] <= pipe[i-1];
         end
         bclk_q <= pipe[STAGES-1][0];
      end
   end

   assign bit_stb = pipe[STAGES-1][0] & ~bclk_q;
   assign lr_bit  = pipe[STAGES-1][1];
   assign sd_bit  = pipe[STAGES-1][2];

endmodule

// File: rtl/sar_deframer.sv
module sar_deframer
   import sar_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  fmt_e             fmt,
   input  logic [1:0]       wsel,
   input  logic             bit_stb,
   input  logic             lr_bit,
   input  logic             sd_bit,
   output logic             word_stb,
   output logic             word_is_left,
   output logic [MAX_W-1:0] word_raw
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (CNT_W < 6) begin : g_cnt_chk
      $error("sar_deframer: CNT_W must cover a 49-bit DSP frame");
   end

   logic             primed, synced, prev_lr;
   logic [CNT_W-1:0] cnt;
   logic [MAX_W-1:0] shreg;

   logic             is_dsp, lr_edge, start, live, fire, left_sel;
   logic [CNT_W-1:0] bidx, dpos, wl;
   logic [MAX_W-1:0] shifted, pick;

   always_comb begin
      is_dsp   = (fmt == FMT_DSP);
      lr_edge  = primed && (lr_bit != prev_lr);
      start    = is_dsp ? lr_bit : lr_edge;
      bidx     = start ? '0 : cnt;
      dpos     = (fmt == FMT_I2S || is_dsp) ? bidx - 1'b1 : bidx;
      wl       = CNT_W'(word_len(wsel));
      live     = synced || start;
      shifted  = {shreg[MAX_W-2:0], sd_bit};
      fire     = 1'b0;
      left_sel = 1'b0;
      pick     = shifted;
      unique case (fmt)
         FMT_RJ: begin
            // word ended on the bit before this transition
            fire     = lr_edge && synced;
            left_sel = ~lr_bit;
            pick     = shreg;
         end
         FMT_LJ, FMT_I2S: begin
            fire     = live && (dpos == wl - 1'b1);
            left_sel = (fmt == FMT_I2S) ? ~lr_bit : lr_bit;
         end
         default: begin
            fire     = live && ((dpos == wl - 1'b1) || (dpos == (wl << 1) - 1'b1));
            left_sel = (dpos == wl - 1'b1);
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         primed       <= 1'b0;
         synced       <= 1'b0;
         prev_lr      <= 1'b0;
         cnt          <= '0;
         shreg        <= '0;
         word_stb     <= 1'b0;
         word_is_left <= 1'b0;
         word_raw     <= '0;
      end else begin
         word_stb <= bit_stb && fire;
         if (bit_stb) begin
            primed  <= 1'b1;
            prev_lr <= lr_bit;
            if (start) synced <= 1'b1;
            cnt   <= start ? CNT_W'(1) : ((cnt == CNT_MAX) ? cnt : cnt + 1'b1);
            shreg <= shifted;
            if (fire) begin
               word_raw     <= pick;
               word_is_left <= left_sel;
            end
         end
      end
   end

endmodule

// File: rtl/sar_zero_det.sv
module sar_zero_det #(
   parameter int LIMIT = 1024,
   parameter int W     = 24
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         frame_stb,
   input  logic [W-1:0] sample,
   output logic         flag
);

   localparam int             CW  = $clog2(LIMIT + 1);
   localparam logic [CW-1:0]  LIM = CW'(LIMIT);

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         run_cnt <= '0;
         flag    <= 1'b0;
      end else if (frame_stb) begin
         if (sample == '0) begin
            if (run_cnt == LIM) flag <= 1'b1;
            else                run_cnt <= run_cnt + 1'b1;
         end else begin
            run_cnt <= '0;
            flag    <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
   import sar_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int ZERO_FRAMES = 1024,
   parameter int CNT_W       = 6
) (
   input  logic        clk,
   input  logic        rst,
   input  logic [1:0]  mode,
   input  logic [1:0]  word_sel,
   input  logic        bclk,
   input  logic        lrclk,
   input  logic        sdata,
   output logic [23:0] left_out,
   output logic [23:0] right_out,
   output logic        out_valid,
   output logic        zero_left,
   output logic        zero_right
);

   localparam int NCH = 2;

   if (SYNC_STAGES < 2) begin : g_sync_chk
      $error("serial_audio_rx: SYNC_STAGES must be at least 2");
   end
   if (ZERO_FRAMES < 1) begin : g_zero_chk
      $error("serial_audio_rx: ZERO_FRAMES must be positive");
   end

   logic             bit_stb, lr_bit, sd_bit;
   logic             word_stb, word_is_left;
   logic [MAX_W-1:0] word_raw, ext, hold_l;
   logic             frame_done;
   logic [NCH-1:0][MAX_W-1:0] chan_next;
   logic [NCH-1:0]   zflag;

   sar_capture #(.STAGES(SYNC_STAGES)) u_cap (
      .clk, .rst, .bclk, .lrclk, .sdata,
      .bit_stb, .lr_bit, .sd_bit
   );

   sar_deframer #(.CNT_W(CNT_W)) u_dfr (
      .clk, .rst,
      .fmt     (fmt_e'(mode)),
      .wsel    (word_sel),
      .bit_stb, .lr_bit, .sd_bit,
      .word_stb, .word_is_left, .word_raw
   );

   assign ext        = sign_fill(word_raw, word_sel);
   assign frame_done = word_stb && !word_is_left;

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_l    <= '0;
         left_out  <= '0;
         right_out <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         if (word_stb) begin
            if (word_is_left) begin
               hold_l <= ext;
            end else begin
               left_out  <= hold_l;
               right_out <= ext;
               out_valid <= 1'b1;
            end
         end
      end
   end

   assign chan_next[0] = hold_l;
   assign chan_next[1] = ext;

   for (genvar c = 0; c < NCH; c++) begin : g_zero
      sar_zero_det #(.LIMIT(ZERO_FRAMES), .W(MAX_W)) u_zd (
         .clk, .rst,
         .frame_stb (frame_done),
         .sample    (chan_next[c]),
         .flag      (zflag[c])
      );
   end

   assign zero_left  = zflag[0];
   assign zero_right = zflag[1];

endmodule

// File: rtl/sar_checker.sv
module sar_checker (
   input logic        clk,
   input logic        rst,
   input logic [1:0]  word_sel,
   input logic [23:0] left_out,
   input logic [23:0] right_out,
   input logic        out_valid,
   input logic        zero_left,
   input logic        zero_right
);

   a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);

   a_r7_hold: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> ($stable(left_out) && $stable(right_out)));

   a_r9_left_rise: assert property (@(posedge clk) disable iff (rst)
      $rose(zero_left) |-> (out_valid && left_out == 24'd0));

   a_r9_right_rise: assert property (@(posedge clk) disable iff (rst)
      $rose(zero_right) |-> (out_valid && right_out == 24'd0));

   a_r10_left_fall: assert property (@(posedge clk) disable iff (rst)
      $fell(zero_left) |-> (out_valid && left_out != 24'd0));

   a_r10_right_fall: assert property (@(posedge clk) disable iff (rst)
      $fell(zero_right) |-> (out_valid && right_out != 24'd0));

   a_r6_ext16: assert property (@(posedge clk) disable iff (rst)
      (out_valid && word_sel == 2'b00) |->
         ((left_out[23:15] == 9'h000 || left_out[23:15] == 9'h1FF) &&
          (right_out[23:15] == 9'h000 || right_out[23:15] == 9'h1FF)));

   a_r11_reset: assert property (@(posedge clk)
      rst |=> (!out_valid && !zero_left && !zero_right &&
               left_out == 24'd0 && right_out == 24'd0));

endmodule

bind serial_audio_rx sar_checker u_chk (.*);

// File: tb/serial_audio_rx_tb.sv
`timescale 1ns/1ps
module serial_audio_rx_tb;

   localparam int ZF = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  mode = 2'b00, wsel = 2'b00;
   logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
   logic [23:0] left_out, right_out;
   logic        out_valid, zero_left, zero_right;

   always #2.5 clk = ~clk;

   serial_audio_rx #(.SYNC_STAGES(2), .ZERO_FRAMES(ZF), .CNT_W(6)) u_dut (
      .clk, .rst, .mode, .word_sel(wsel), .bclk, .lrclk, .sdata,
      .left_out, .right_out, .out_valid, .zero_left, .zero_right
   );

   int          checks = 0, fails = 0;
   logic [23:0] raw_l [0:15];
   logic [23:0] raw_r [0:15];
   int          nfr = 0, cap = 0, w = 16, zc_l = 0, zc_r = 0;
   logic        ef_l = 1'b0, ef_r = 1'b0;
   bit          mon_on = 0, gating = 0;
   string       tag = "";
   logic [15:0] lfsr = 16'hACE1;
   logic [23:0] el, er;

   task automatic chk(input bit ok, input string what, input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   function automatic logic [23:0] ext(input logic [23:0] raw, input int wl);
      logic [23:0] m;
      m = (24'd1 << wl) - 24'd1;
      return raw[wl-1] ? (raw | ~m) : (raw & m);
   endfunction

   function automatic logic [23:0] gen(input int k, input int s, input int wl);
      logic [23:0] m;
      m = (24'd1 << wl) - 24'd1;
      case (k % 6)
         0:       return m >> 1;
         1:       return 24'd1 << (wl - 1);
         2:       return m;
         3:       return 24'd1;
         4:       return 24'hAAAAAA & m;
         default: return 24'(k * 40503 + s * 977 + 5) & m;
      endcase
   endfunction

   // output monitor with independent silence model
   always @(negedge clk) begin
      if (mon_on && out_valid) begin
         if (cap < nfr) begin
            el = ext(raw_l[cap], w);
            er = ext(raw_r[cap], w);
            if (el == 24'd0) begin if (zc_l < ZF) zc_l++; else ef_l = 1'b1; end
            else begin zc_l = 0; ef_l = 1'b0; end
            if (er == 24'd0) begin if (zc_r < ZF) zc_r++; else ef_r = 1'b1; end
            else begin zc_r = 0; ef_r = 1'b0; end
            chk(left_out == el,  $sformatf("%s left frame %0d", tag, cap), left_out, el);
            chk(right_out == er, $sformatf("%s right frame %0d", tag, cap), right_out, er);
            chk(zero_left == ef_l,  $sformatf("R9 R10 left flag frame %0d", cap),
                24'(zero_left), 24'(ef_l));
            chk(zero_right == ef_r, $sformatf("R9 R10 right flag frame %0d", cap),
                24'(zero_right), 24'(ef_r));
         end else begin
            chk(1'b0, "R7 extra valid pulse", 24'(cap), 24'(nfr));
         end
         cap++;
      end
   end

   task automatic send_bit(input logic l, input logic d);
      @(negedge clk);
      bclk = 1'b0; lrclk = l; sdata = d;
      @(negedge clk);
      if (gating && lfsr[0]) repeat (5) @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      @(negedge clk);
      bclk = 1'b1;
      @(negedge clk);
   endtask

   function automatic logic half_bit(input logic [1:0] m, input logic [23:0] raw, input int i, input int wl);
      int p;
      case (m)
         2'b10:   p = i;
         2'b01:   p = i - 1;
         default: p = i - (32 - wl);
      endcase
      if (p >= 0 && p < wl) return raw[wl-1-p];
      return (i % 2) == 1;
   endfunction

   task automatic send_half(input logic [1:0] m, input logic l, input logic [23:0] raw);
      for (int i = 0; i < 32; i++) send_bit(l, half_bit(m, raw, i, w));
   endtask

   task automatic send_dsp(input logic [23:0] rl, input logic [23:0] rr);
      for (int i = 0; i < 64; i++) begin
         int p;
         p = i - 1;
         if (i == 0)         send_bit(1'b1, 1'b1);
         else if (p < w)     send_bit(1'b0, rl[w-1-p]);
         else if (p < 2 * w) send_bit(1'b0, rr[2*w-1-p]);
         else                send_bit(1'b0, (i % 2) == 1);
      end
   endtask

   task automatic run(input logic [1:0] m, input logic [1:0] ws, input bit g, input int n, input string base);
      logic lvl;
      mode = m; wsel = ws; gating = g; nfr = n;
      w = (ws == 2'd0) ? 16 : (ws == 2'd1) ? 18 : (ws == 2'd2) ? 20 : 24;
      tag = {base, " R6", g ? " R8" : ""};
      lvl = (m == 2'b01) ? 1'b0 : 1'b1;
      rst = 1'b1; bclk = 1'b0; lrclk = ~lvl; sdata = 1'b0;
      if (m == 2'b11) lrclk = 1'b0;
      repeat (4) @(negedge clk);
      cap = 0; zc_l = 0; zc_r = 0; ef_l = 1'b0; ef_r = 1'b0;
      rst = 1'b0;
      @(negedge clk);
      chk(!out_valid && left_out == 0 && right_out == 0 && !zero_left && !zero_right,
          "R11 state after reset", left_out, 24'd0);
      mon_on = 1;
      if (m == 2'b11) begin
         for (int i = 0; i < 8; i++) send_bit(1'b0, 1'b1);
         for (int k = 0; k < n; k++) send_dsp(raw_l[k], raw_r[k]);
         for (int i = 0; i < 8; i++) send_bit(1'b0, 1'b0);
      end else begin
         send_half(m, ~lvl, 24'd0);
         for (int k = 0; k < n; k++) begin
            send_half(m, lvl, raw_l[k]);
            send_half(m, ~lvl, raw_r[k]);
         end
         send_half(m, lvl, 24'd0);
      end
      repeat (20) @(negedge clk);
      chk(cap == n, {tag, " R1 R7 frame count"}, 24'(cap), 24'(n));
      mon_on = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!out_valid && !zero_left && !zero_right, "R11 during reset", 24'(out_valid), 24'd0);
      for (int m = 0; m < 4; m++) begin
         for (int ws = 0; ws < 4; ws++) begin
            int wl;
            string base;
            wl = (ws == 0) ? 16 : (ws == 1) ? 18 : (ws == 2) ? 20 : 24;
            for (int k = 0; k < 6; k++) begin
               raw_l[k] = gen(k, m * 4 + ws, wl);
               raw_r[k] = gen(k + 3, m * 4 + ws + 1, wl);
            end
            base = (m == 0) ? "R4 right-justified" : (m == 1) ? "R3 i2s" :
                   (m == 2) ? "R2 left-justified" : "R5 dsp";
            run(2'(m), 2'(ws), (ws % 2) == 1, 6, base);
         end
      end
      // silence flag run: left reaches the threshold twice, right stays below
      for (int k = 0; k < 12; k++) begin
         raw_l[k] = (k == 6) ? 24'd5 : 24'd0;
         raw_r[k] = (k < 4) ? 24'd0 : 24'(k);
      end
      run(2'b10, 2'b11, 1'b0, 12, "R9 R10 R2 silence");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #900000;
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual %0d expected %0d", cap, nfr);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule